// File: doc/BRIEF.md
# Cache Victim Way Selector

This block chooses which way of a highly associative cache is overwritten on each line fill. A fill request carries two things: a transient flag, taken from the page attribute of the access, and a set-group selector. The block returns the victim way in the same cycle. On the clock edge that ends the request, it advances the round-robin index it used.

A single 32-bit control register sets the replacement regions. It has three fields: a normal floor, a transient floor and a transient ceiling. The normal floor locks every way below it against normal fills. Normal fills rotate through the ways from the normal floor up to the highest way. Transient fills rotate through the ways from the transient floor up to the transient ceiling. There are four independent normal indices, selected by the set group, and one transient index.

When the register is written, any index that falls outside its new window is moved to that window's floor. Software reads the register back through the same port.

Top module: `cache_victim_sel`

## Requirements
- R1: After reset, cfg_rdata_o is 0 and every index holds way 0. The victim is therefore 0 for every group and for transient fills.
- R2: The fields of cfg_rdata_o sit at fixed bit positions. The normal floor is at bits [7:0], the transient ceiling at [18:11] and the transient floor at [29:22]. Only the low WAY_W bits of each field are stored. All other bits read as 0. A write takes effect on the clock edge that ends it.
- R3: victim_o is combinational. When fill_transient_i is 0 it shows the normal index selected by fill_group_i. When fill_transient_i is 1 it shows the transient index.
- R4: A normal fill (fill_req_i=1, fill_transient_i=0) advances the selected normal index by one. From way NUM_WAYS-1 it wraps to the normal floor.
- R5: A normal fill never returns a way below the normal floor.
- R6: A transient fill returns a way in [transient floor, transient ceiling] and advances the transient index by one. From the ceiling it wraps to the floor. If the ceiling is below the floor, the window is the floor way alone.
- R7: A fill advances only the index it used. The other three normal indices and the transient index keep their values.
- R8: On a register write, each index that lies outside its new window is set to that window's floor. An index inside its new window keeps its value.
- R9: When a fill and a register write occur in the same cycle, the returned victim is the old index. The index is first advanced inside the old window. R8 is then applied to the result using the new window.
- R10: While fill_req_i is 0 and no write occurs, no index changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control register write data |
| cfg_rdata_o | output | 32 | Control register read data |
| fill_req_i | input | 1 | One-cycle fill strobe |
| fill_transient_i | input | 1 | Fill comes from a transient page |
| fill_group_i | input | 2 | Selects the normal victim index |
| victim_o | output | WAY_W (6) | Way to replace |

## Verification
A fill and a register write can land in the same cycle. In that cycle the victim must come from the old index, and the step must wrap inside the old window before the new window re-bounds the result. The bench provokes this on purpose: it writes a floor that overtakes the index being filled, and it writes a window that the advanced transient index leaves. A random phase also raises writes alongside fills. A behavioural model updates its indices in that same order, and both the victim and the readback are compared against it on every clock.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;
  localparam int CFG_W  = 32;
  localparam int NF_LSB = 0;
  localparam int TC_LSB = 11;
  localparam int TF_LSB = 22;
  localparam int FLD_W  = 8;
endpackage

// File: rtl/vs_cfg_reg.sv
module vs_cfg_reg
  import victim_sel_pkg::*;
#(
  parameter int WAY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [WAY_W-1:0] nfloor_o,
  output logic [WAY_W-1:0] tfloor_o,
  output logic [WAY_W-1:0] tceil_o,
  output logic [WAY_W-1:0] nxt_nfloor_o,
  output logic [WAY_W-1:0] nxt_tfloor_o,
  output logic [WAY_W-1:0] nxt_tceil_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic [WAY_W-1:0] nf_q, tf_q, tc_q;

  always_comb begin
    nxt_nfloor_o = we_i ? wdata_i[NF_LSB +: WAY_W] : nf_q;
    nxt_tfloor_o = we_i ? wdata_i[TF_LSB +: WAY_W] : tf_q;
    nxt_tceil_o  = we_i ? wdata_i[TC_LSB +: WAY_W] : tc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nf_q <= '0;
      tf_q <= '0;
      tc_q <= '0;
    end else begin
      nf_q <= nxt_nfloor_o;
      tf_q <= nxt_tfloor_o;
      tc_q <= nxt_tceil_o;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[NF_LSB +: WAY_W] = nf_q;
    rdata_o[TC_LSB +: WAY_W] = tc_q;
    rdata_o[TF_LSB +: WAY_W] = tf_q;
  end

  assign nfloor_o = nf_q;
  assign tfloor_o = tf_q;
  assign tceil_o  = tc_q;
endmodule

// File: rtl/vs_rr_index.sv
module vs_rr_index #(
  parameter int WAY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [WAY_W-1:0] floor_i,
  input  logic [WAY_W-1:0] ceil_i,
  input  logic [WAY_W-1:0] nxt_floor_i,
  input  logic [WAY_W-1:0] nxt_ceil_i,
  output logic [WAY_W-1:0] idx_o
);
  logic [WAY_W-1:0] idx_q, stepped, idx_d;

  // step inside current window, then re-bound against the window after any write
  always_comb begin
    stepped = idx_q;
    if (adv_i) stepped = (idx_q >= ceil_i) ? floor_i : WAY_W'(idx_q + 1'b1);
    idx_d = (stepped < nxt_floor_i || stepped > nxt_ceil_i) ? nxt_floor_i : stepped;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import victim_sel_pkg::*;
#(
  parameter int NUM_WAYS   = 64,
  parameter int NUM_GROUPS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int GRP_W = $clog2(NUM_GROUPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             fill_req_i,
  input  logic             fill_transient_i,
  input  logic [GRP_W-1:0] fill_group_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  logic [WAY_W-1:0] nfloor_q, tfloor_q, tceil_q;
  logic [WAY_W-1:0] nxt_nfloor, nxt_tfloor, nxt_tceil;
  logic [WAY_W-1:0] tceil_eff, nxt_tceil_eff;
  logic [WAY_W-1:0] nidx [NUM_GROUPS];
  logic [WAY_W-1:0] tidx;

  vs_cfg_reg #(.WAY_W(WAY_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .nfloor_o    (nfloor_q),
    .tfloor_o    (tfloor_q),
    .tceil_o     (tceil_q),
    .nxt_nfloor_o(nxt_nfloor),
    .nxt_tfloor_o(nxt_tfloor),
    .nxt_tceil_o (nxt_tceil),
    .rdata_o     (cfg_rdata_o)
  );

  // a ceiling under the floor collapses the window to the floor way
  assign tceil_eff     = (tceil_q < tfloor_q) ? tfloor_q : tceil_q;
  assign nxt_tceil_eff = (nxt_tceil < nxt_tfloor) ? nxt_tfloor : nxt_tceil;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_norm
    vs_rr_index #(.WAY_W(WAY_W)) u_idx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .adv_i      (fill_req_i && !fill_transient_i && (fill_group_i == GRP_W'(g))),
      .floor_i    (nfloor_q),
      .ceil_i     (LAST_WAY),
      .nxt_floor_i(nxt_nfloor),
      .nxt_ceil_i (LAST_WAY),
      .idx_o      (nidx[g])
    );
  end

  vs_rr_index #(.WAY_W(WAY_W)) u_tidx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (fill_req_i && fill_transient_i),
    .floor_i    (tfloor_q),
    .ceil_i     (tceil_eff),
    .nxt_floor_i(nxt_tfloor),
    .nxt_ceil_i (nxt_tceil_eff),
    .idx_o      (tidx)
  );

  assign victim_o = fill_transient_i ? tidx : nidx[fill_group_i];
endmodule

// File: rtl/cache_victim_sel_checker.sv
module cache_victim_sel_checker
  import victim_sel_pkg::*;
#(
  parameter int WAY_W = 6,
  parameter int GRP_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             fill_req_i,
  input logic             fill_transient_i,
  input logic [GRP_W-1:0] fill_group_i,
  input logic [WAY_W-1:0] victim_o,
  input logic [WAY_W-1:0] nfloor_q,
  input logic [WAY_W-1:0] tfloor_q,
  input logic [WAY_W-1:0] tceil_eff
);
  localparam logic [CFG_W-1:0] ONES = CFG_W'((64'd1 << WAY_W) - 1);
  localparam logic [CFG_W-1:0] FMASK = (ONES << NF_LSB) | (ONES << TC_LSB) | (ONES << TF_LSB);
  localparam logic [WAY_W-1:0] LAST_WAY = '1;

  p_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_we_i) |-> cfg_rdata_o == ($past(cfg_wdata_i) & FMASK));

  p_normal_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && !fill_transient_i) |-> victim_o >= nfloor_q);

  p_transient_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && fill_transient_i) |-> (victim_o >= tfloor_q && victim_o <= tceil_eff));

  p_normal_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && !fill_transient_i && $past(fill_req_i && !fill_transient_i && !cfg_we_i)
     && fill_group_i == $past(fill_group_i) && $past(victim_o) != LAST_WAY)
    |-> victim_o == WAY_W'($past(victim_o) + 1'b1));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!fill_req_i && !cfg_we_i) && $stable(fill_group_i) && $stable(fill_transient_i))
    |-> $stable(victim_o));
endmodule

bind cache_victim_sel cache_victim_sel_checker #(.WAY_W(WAY_W), .GRP_W(GRP_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_we_i        (cfg_we_i),
  .cfg_wdata_i     (cfg_wdata_i),
  .cfg_rdata_o     (cfg_rdata_o),
  .fill_req_i      (fill_req_i),
  .fill_transient_i(fill_transient_i),
  .fill_group_i    (fill_group_i),
  .victim_o        (victim_o),
  .nfloor_q        (nfloor_q),
  .tfloor_q        (tfloor_q),
  .tceil_eff       (tceil_eff)
);

// File: tb/cache_victim_sel_test.sv
`timescale 1ns/1ps
module cache_victim_sel_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        fill_req_i = 1'b0;
  logic        fill_transient_i = 1'b0;
  logic [1:0]  fill_group_i = '0;
  logic [5:0]  victim_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int nidx[4];
  int tidx, nf, tf, tc;

  always #2.5 clk = ~clk;

  cache_victim_sel uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .fill_req_i(fill_req_i), .fill_transient_i(fill_transient_i),
    .fill_group_i(fill_group_i), .victim_o(victim_o)
  );

  function automatic int tce();
    return (tc < tf) ? tf : tc;
  endfunction

  function automatic int exp_rdata();
    return nf | (tc << 11) | (tf << 22);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive after negedge, compare, then advance model across the edge
  task automatic cyc(bit req, bit tr, int grp, bit we, int wd, string tag);
    int ev;
    fill_req_i = req; fill_transient_i = tr; fill_group_i = 2'(grp);
    cfg_we_i = we; cfg_wdata_i = wd;
    #1;
    ev = tr ? tidx : nidx[grp];
    check({tag, " victim"}, int'(victim_o), ev);
    check({tag, " R2 rdata"}, int'(cfg_rdata_o), exp_rdata());
    @(posedge clk);
    if (req) begin
      if (tr) tidx = (tidx >= tce()) ? tf : tidx + 1;
      else    nidx[grp] = (nidx[grp] >= 63) ? nf : nidx[grp] + 1;
    end
    if (we) begin
      nf = wd & 63; tc = (wd >> 11) & 63; tf = (wd >> 22) & 63;
      for (int g = 0; g < 4; g++) if (nidx[g] < nf) nidx[g] = nf;
      if (tidx < tf || tidx > tce()) tidx = tf;
    end
    @(negedge clk);
  endtask

  function automatic int cfgw(int nfl, int tfl, int tcl);
    return nfl | (tcl << 11) | (tfl << 22);
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 4; g++) nidx[g] = 0;
    tidx = 0; nf = 0; tf = 0; tc = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int g = 0; g < 4; g++) cyc(0, 0, g, 0, 0, "R1");
    cyc(0, 1, 0, 0, 0, "R1");
    // R3 R4 plain rotation in group 0
    repeat (5) cyc(1, 0, 0, 0, 0, "R3 R4");
    // R7 other groups untouched
    for (int g = 1; g < 4; g++) cyc(0, 0, g, 0, 0, "R7");
    // R8 lock ways below 60
    cyc(0, 0, 0, 1, cfgw(60, 0, 0), "R8");
    for (int g = 0; g < 4; g++) cyc(0, 0, g, 0, 0, "R8");
    // R4 R5 wrap to the normal floor
    repeat (6) cyc(1, 0, 1, 0, 0, "R4 R5");
    cyc(1, 0, 2, 0, 0, "R7");
    cyc(0, 0, 1, 0, 0, "R7");
    // R6 transient window 10..12
    cyc(0, 1, 0, 1, cfgw(60, 10, 12), "R6 R8");
    repeat (5) cyc(1, 1, 0, 0, 0, "R6");
    cyc(0, 0, 2, 0, 0, "R7");
    // R6 ceiling below floor collapses window
    cyc(0, 1, 0, 1, cfgw(60, 10, 5), "R6 R8");
    repeat (3) cyc(1, 1, 0, 0, 0, "R6");
    // R10 idle with changing selectors
    for (int g = 0; g < 4; g++) cyc(0, g[0], g, 0, 0, "R10");
    // R9 fill while floor overtakes the filled index
    cyc(0, 0, 3, 0, 0, "R9");
    cyc(1, 0, 3, 1, cfgw(62, 20, 30), "R9");
    for (int g = 0; g < 4; g++) cyc(0, 0, g, 0, 0, "R9");
    repeat (3) cyc(1, 1, 0, 0, 0, "R6");
    // R9 transient step at ceiling with window moving
    cyc(0, 1, 0, 1, cfgw(0, 21, 22), "R9");
    cyc(1, 1, 0, 0, 0, "R9");
    cyc(1, 1, 0, 1, cfgw(0, 21, 21), "R9");
    cyc(1, 1, 0, 0, 0, "R9");
    // R2 all-ones write
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF, "R2");
    cyc(1, 0, 0, 0, 0, "R2 R5");
    cyc(0, 0, 0, 1, cfgw(8, 4, 40), "R2");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      int w = $urandom;
      cyc(r < 70, $urandom_range(0, 2) == 0, $urandom_range(0, 3), r >= 95,
          (r >= 98) ? cfgw($urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 63)) : w,
          "R3");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule